// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital engine of a successive approximation converter. A start request accepted while the block is idle opens a fixed sampling window. The block then resolves the result one bit per clock, from the most significant bit down. In every bit cycle it drives a trial code to the capacitor DAC and reads back a single comparator bit. The bit under trial is kept when the comparator reports that the input is at or above the trial level, and cleared otherwise.

Each decided bit appears on a serial output as soon as it is known. When the last bit is decided, the complete code is loaded into a parallel output and end-of-conversion is raised. Resolution is either the full 12 bits or a reduced 10 bits. If start is still high when the final bit is decided, the next conversion begins at once, so that holding start high gives the highest conversion rate.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, eoc_o, sample_o, serial_o, dac_code_o and data_o are all zero.
- R2: When start_i is high at a clock edge while the block is idle, that edge accepts a conversion. sample_o is then high for exactly 2 cycles, with dac_code_o at zero.
- R3: Bit cycles run from bit 11 downward. In each one, dac_code_o holds the bits already decided above the current position, a 1 at the current position, and zeros below it. The current bit stays 1 when cmp_i is 1 at the closing edge of the cycle (cmp_i = 1 means the input is at or above the trial code), and becomes 0 otherwise.
- R4: From the edge that decides a bit, serial_o shows that bit, and it holds the value until the next decision.
- R5: With res_low_i = 0 there are 12 bit cycles. eoc_o rises 14 edges after the accepting edge, and data_o then equals the 12-bit code.
- R6: With res_low_i = 1 there are 10 bit cycles, for bits 11 to 2. eoc_o rises 12 edges after the accepting edge, and data_o[1:0] reads 0.
- R7: After a conversion completes, eoc_o stays high until a new conversion is accepted. data_o changes only on an edge where eoc_o rises.
- R8: If start_i is high on the edge that decides the final bit, the next sampling window begins in the very next cycle. eoc_o is high during that first sampling cycle only.
- R9: res_low_i is captured on the accepting edge. Changes to it during a conversion have no effect on that conversion.
- R10: A start_i pulse while a conversion is in progress, other than on its final bit edge, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled at rising edges |
| res_low_i | input | 1 | 1 selects 10-bit resolution, 0 selects 12-bit |
| cmp_i | input | 1 | Comparator result, 1 when the input is at or above the trial code |
| sample_o | output | 1 | High during the sampling window |
| dac_code_o | output | 12 | Trial code driven to the DAC |
| serial_o | output | 1 | Most recently decided result bit |
| data_o | output | 12 | Completed conversion code |
| eoc_o | output | 1 | End of conversion |

## Verification
The hardest case to reach is the seamless hand-over between conversions. Here eoc_o rises and the next sampling window starts on the same edge. A resolution change and a stray start pulse must also land at exact points inside a conversion. The stimulus holds start_i high across long back-to-back sweeps, first of every 12-bit input and then of a strided 10-bit set. Separate runs toggle res_low_i after the accepting edge and pulse start_i in the middle of the bit cycles. The comparator model compares the bench's input value with dac_code_o, so every trial code is checked cycle by cycle.

// File: rtl/sar_core_pkg.sv
package sar_core_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_BIT    = 2'd2
  } sar_phase_e;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_core_pkg::*;
#(
  parameter int MAX_BITS      = 12,
  parameter int LOW_DROP      = 2,
  parameter int SAMPLE_CYCLES = 2,
  localparam int CNT_W = $clog2(SAMPLE_CYCLES + MAX_BITS),
  localparam int IDX_W = $clog2(MAX_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             res_low_i,
  output sar_phase_e       phase_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             last_o,
  output logic             accept_o
);
  logic             busy_q, res_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] bit_num;
  logic [IDX_W-1:0] stop_idx;

  always_comb begin
    if (!busy_q)                                phase_o = PH_IDLE;
    else if (cnt_q < CNT_W'(SAMPLE_CYCLES))     phase_o = PH_SAMPLE;
    else                                        phase_o = PH_BIT;
    bit_num   = cnt_q - CNT_W'(SAMPLE_CYCLES);
    bit_idx_o = IDX_W'(MAX_BITS - 1) - IDX_W'(bit_num);
    stop_idx  = res_q ? IDX_W'(LOW_DROP) : '0;
    last_o    = (phase_o == PH_BIT) && (bit_idx_o == stop_idx);
    // a start on the final decision edge chains straight into sampling
    accept_o  = start_i && (!busy_q || last_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      res_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      res_q  <= res_low_i;
      cnt_q  <= '0;
    end else if (last_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sar_trial.sv
module sar_trial
  import sar_core_pkg::*;
#(
  parameter int MAX_BITS = 12,
  localparam int IDX_W = $clog2(MAX_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  sar_phase_e          phase_i,
  input  logic [IDX_W-1:0]    bit_idx_i,
  input  logic                last_i,
  input  logic                accept_i,
  input  logic                cmp_i,
  output logic [MAX_BITS-1:0] dac_code_o,
  output logic [MAX_BITS-1:0] decided_o
);
  logic [MAX_BITS-1:0] sar_q;
  logic [MAX_BITS-1:0] mask;

  always_comb begin
    mask       = MAX_BITS'(1) << bit_idx_i;
    decided_o  = sar_q | (cmp_i ? mask : '0);
    dac_code_o = (phase_i == PH_BIT) ? (sar_q | mask) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sar_q <= '0;
    else if (last_i || accept_i) sar_q <= '0;
    else if (phase_i == PH_BIT)  sar_q <= decided_o;
  end
endmodule

// File: rtl/sar_result.sv
module sar_result
  import sar_core_pkg::*;
#(
  parameter int MAX_BITS = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  sar_phase_e          phase_i,
  input  logic                last_i,
  input  logic                accept_i,
  input  logic                cmp_i,
  input  logic [MAX_BITS-1:0] decided_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic                eoc_o,
  output logic                serial_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      eoc_o  <= 1'b0;
    end else if (last_i) begin
      data_o <= decided_i;
      eoc_o  <= 1'b1;
    end else if (accept_i || phase_i != PH_IDLE) begin
      eoc_o  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                serial_o <= 1'b0;
    else if (phase_i == PH_BIT) serial_o <= cmp_i;
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_core_pkg::*;
#(
  parameter int MAX_BITS      = 12,
  parameter int LOW_DROP      = 2,
  parameter int SAMPLE_CYCLES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                res_low_i,
  input  logic                cmp_i,
  output logic                sample_o,
  output logic [MAX_BITS-1:0] dac_code_o,
  output logic                serial_o,
  output logic [MAX_BITS-1:0] data_o,
  output logic                eoc_o
);
  localparam int IDX_W = $clog2(MAX_BITS);

  sar_phase_e          phase;
  logic [IDX_W-1:0]    bit_idx;
  logic                last_bit, accept;
  logic [MAX_BITS-1:0] decided;

  sar_seq #(
    .MAX_BITS(MAX_BITS), .LOW_DROP(LOW_DROP), .SAMPLE_CYCLES(SAMPLE_CYCLES)
  ) seq_i (
    .clk_i, .rst_ni, .start_i, .res_low_i,
    .phase_o(phase), .bit_idx_o(bit_idx), .last_o(last_bit), .accept_o(accept)
  );

  sar_trial #(.MAX_BITS(MAX_BITS)) trial_i (
    .clk_i, .rst_ni, .phase_i(phase), .bit_idx_i(bit_idx), .last_i(last_bit),
    .accept_i(accept), .cmp_i, .dac_code_o, .decided_o(decided)
  );

  sar_result #(.MAX_BITS(MAX_BITS)) result_i (
    .clk_i, .rst_ni, .phase_i(phase), .last_i(last_bit), .accept_i(accept),
    .cmp_i, .decided_i(decided), .data_o, .eoc_o, .serial_o
  );

  assign sample_o = (phase == PH_SAMPLE);
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int MAX_BITS = 12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                sample_o,
  input logic [MAX_BITS-1:0] dac_code_o,
  input logic                serial_o,
  input logic [MAX_BITS-1:0] data_o,
  input logic                eoc_o
);
  AST_DAC_IDLE_IN_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> dac_code_o == '0); // R2

  AST_START_OPENS_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_i && !sample_o && dac_code_o == '0) |-> sample_o); // R2

  AST_SERIAL_ONLY_ON_DECISION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dac_code_o == '0) |-> $stable(serial_o)); // R4

  AST_EOC_AFTER_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eoc_o) |-> $past(!sample_o && dac_code_o != '0)); // R5

  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(eoc_o) |-> $stable(data_o)); // R7
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.MAX_BITS(MAX_BITS)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .sample_o(sample_o),
  .dac_code_o(dac_code_o), .serial_o(serial_o), .data_o(data_o), .eoc_o(eoc_o)
);

// File: tb/sar_adc_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_adc_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        res_low = 1'b0;
  logic        cmp;
  logic        sample;
  logic [11:0] dac_code;
  logic        serial;
  logic [11:0] data;
  logic        eoc;
  logic [11:0] vin = '0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  // ideal comparator against the bench's input level
  assign cmp = (vin >= dac_code);

  sar_adc_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .res_low_i(res_low),
    .cmp_i(cmp), .sample_o(sample), .dac_code_o(dac_code), .serial_o(serial),
    .data_o(data), .eoc_o(eoc)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one conversion; entered=1 means the accepting edge was the previous final edge
  task automatic conv(input logic [11:0] v, input logic low, input logic entered,
                      input logic hold, input logic poke, input logic flip);
    int          nb;
    logic [11:0] code, trial, expv;
    logic [11:0] prev;
    logic        b;
    nb   = low ? 10 : 12;
    code = '0;
    prev = data;
    vin  = v;
    if (!entered) begin
      res_low = low;
      start   = 1'b1;
      @(posedge clk); #1;
      check(eoc == 1'b0, "R2 eoc falls on accept", int'(eoc), 0);
    end
    start = hold;
    for (int s = 0; s < 2; s++) begin
      @(negedge clk);
      check(sample == 1'b1, "R2 sample window", int'(sample), 1);
      check(dac_code == 12'd0, "R2 dac zero while sampling", int'(dac_code), 0);
      if (s == 0 && entered) begin
        check(eoc == 1'b1, "R8 eoc during first chained sample", int'(eoc), 1);
        check(data == prev, "R7 data held into next conversion", int'(data), int'(prev));
      end
      if (s == 1) check(eoc == 1'b0, "R8 eoc low by second sample", int'(eoc), 0);
      @(posedge clk); #1;
    end
    if (flip) res_low = ~low;
    for (int k = 0; k < nb; k++) begin
      trial = code | (12'd1 << (11 - k));
      if (poke && k == 3) start = 1'b1;
      @(negedge clk);
      check(dac_code == trial, "R3 trial code", int'(dac_code), int'(trial));
      check(sample == 1'b0 && eoc == 1'b0, "R5 busy without eoc", int'({sample, eoc}), 0);
      b = (v >= trial);
      if (b) code = trial;
      @(posedge clk); #1;
      if (poke && k == 3) start = hold;
      check(serial == b, "R4 serial bit", int'(serial), int'(b));
    end
    expv = low ? {v[11:2], 2'b00} : v;
    check(eoc == 1'b1, low ? "R6 eoc after 12 edges" : "R5 eoc after 14 edges", int'(eoc), 1);
    check(data == expv, low ? "R6 10-bit code" : "R5 12-bit code", int'(data), int'(expv));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] held;
    repeat (3) @(posedge clk);
    #1;
    check(eoc == 0 && sample == 0 && serial == 0, "R1 reset controls", int'({eoc, sample, serial}), 0);
    check(dac_code == 0 && data == 0, "R1 reset codes", int'(dac_code | data), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    conv(12'd0,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    conv(12'd4095, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    conv(12'd2731, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R10: stray start mid-conversion
    conv(12'd1365, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    // R9: resolution change during conversion ignored, taken by the chained one
    conv(12'd1027, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    conv(12'd1027, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    conv(12'd3001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);

    // R7: idle holds eoc and data
    held = data;
    repeat (3) @(posedge clk);
    #1;
    check(eoc == 1'b1 && sample == 1'b0, "R7 eoc held in idle", int'({eoc, sample}), 2);
    check(data == held, "R7 data held in idle", int'(data), int'(held));

    // R8: back-to-back full sweep of every 12-bit input
    res_low = 1'b0;
    for (int v = 0; v < 4096; v++)
      conv(12'(v), 1'b0, v != 0, v != 4095, 1'b0, 1'b0);
    // R6: back-to-back strided 10-bit sweep
    res_low = 1'b1;
    for (int v = 0; v < 4096; v += 3)
      conv(12'(v), 1'b1, v != 0, v + 3 < 4096, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule